// File: doc/BRIEF.md
# Bi-phase Packet Demodulator

This block sits behind the slicer of a wireless power transmitter. It takes the already digitised hi/lo modulation level that a receiver impresses on the coil and turns it into message bytes. First it filters glitches off the level. It then times the gap between successive transitions and sorts each gap as half a bit cell or a whole bit cell. Two half-cell gaps in a row give a one bit. One whole-cell gap gives a zero bit. At the nominal 2 kHz bit rate these gaps are about 250 us and 500 us.

The recovered bit stream is searched for a run of ones that acts as a preamble. The zero that follows the run starts the first byte. Each byte is an 11-bit asynchronous character: a zero start bit, eight data bits sent least significant first, an odd parity bit and a one stop bit. The first byte is a header, and the header fixes how many message bytes follow. A checksum byte then closes the packet.

Downstream logic sees a byte stream with a valid strobe. Packet-start and packet-end flags ride on the header byte and the checksum byte. A checksum-mismatch flag rides on the packet end. A separate error strobe with a cause code reports any packet that was dropped part way through. Timing is set by parameters in clock cycles: the half-cell length, the glitch hold time and the minimum preamble length.

Top module: `biphase_pkt_demod`

## Requirements
- R1: A level change on `mod_i` that lasts fewer than GLITCH_CYC clock cycles is ignored. A change that lasts at least that long is accepted as a transition.
- R2: A gap between accepted transitions counts as a half cell when it lies within HALF_CYC ±25%, and as a whole cell when it lies within 2·HALF_CYC ±25%. Two consecutive half cells decode as a one bit. A single whole cell decodes as a zero bit.
- R3: A packet starts only when a zero bit follows at least PREAMBLE_MIN consecutive one bits. A shorter run of ones followed by a zero produces no output.
- R4: Each byte is a zero start bit, eight data bits with the least significant bit first, a parity bit and a stop bit. A byte with odd parity over data plus parity and a one stop bit appears on `byte_o` with `byte_vld_o` high for one cycle.
- R5: The header byte sets the message length. Values below 0x20 give 1 byte. Values 0x20 to 0x7F give 2 + ((hdr − 0x20) >> 4) bytes. Values 0x80 to 0xFF give 8 + ((hdr − 0x80) >> 3) bytes. The byte after the message bytes is the checksum.
- R6: `pkt_start_o` is high together with the header byte's `byte_vld_o`. `pkt_end_o` is high together with the checksum byte's `byte_vld_o`. Both flags are low for all other bytes.
- R7: `chk_err_o`, qualified by `pkt_end_o`, is high exactly when the checksum byte differs from the XOR of the header and all message bytes.
- R8: A byte whose parity is even drops the packet. `err_o` pulses with `err_code_o` = 2, and no more bytes come out until a new preamble arrives.
- R9: A zero stop bit, or a one where a start bit is expected between bytes, drops the packet with `err_code_o` = 3. A bad stop bit takes priority over a bad parity bit.
- R10: Inside a packet, a gap that fits neither window, a whole cell that arrives in the middle of a one bit, or a silence longer than the whole-cell window drops the packet with `err_code_o` = 1.
- R11: Out-of-window gaps and silences seen while searching for a preamble never pulse `err_o`.
- R12: After reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mod_i | input | 1 | Sliced modulation level (asynchronous) |
| byte_o | output | 8 | Received byte |
| byte_vld_o | output | 1 | One-cycle strobe for `byte_o` |
| pkt_start_o | output | 1 | Current byte is a packet header |
| pkt_end_o | output | 1 | Current byte is a packet checksum |
| chk_err_o | output | 1 | Checksum mismatch, valid with `pkt_end_o` |
| err_o | output | 1 | One-cycle strobe: packet dropped |
| err_code_o | output | 2 | Drop cause: 1 timing, 2 parity, 3 framing |

## Verification
The bound checker watches the output flags on every cycle. The start and end flags must only appear on a valid byte and never together. A checksum flag must only appear with a packet end. An error strobe must carry a nonzero cause, must never coincide with a byte, and must not be followed by a byte on the next cycle. Several things can only be shown by the bench's scenarios, because they depend on what was sent over many bit cells: the bit values and byte contents, the header-to-length mapping, glitch rejection, the preamble threshold, the choice of cause code for each kind of corruption, and the silence of error reporting during preamble search.

// File: rtl/biphase_pkt_demod.sv
module biphase_pkt_demod #(
  parameter int HALF_CYC     = 250,
  parameter int GLITCH_CYC   = 150,
  parameter int PREAMBLE_MIN = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mod_i,
  output logic [7:0] byte_o,
  output logic       byte_vld_o,
  output logic       pkt_start_o,
  output logic       pkt_end_o,
  output logic       chk_err_o,
  output logic       err_o,
  output logic [1:0] err_code_o
);
  localparam int FULL_CYC = 2 * HALF_CYC;
  localparam int S_MIN = HALF_CYC - HALF_CYC / 4;
  localparam int S_MAX = HALF_CYC + HALF_CYC / 4;
  localparam int L_MIN = FULL_CYC - FULL_CYC / 4;
  localparam int L_MAX = FULL_CYC + FULL_CYC / 4;
  localparam int CW = $clog2(L_MAX + 3);
  localparam int GW = $clog2(GLITCH_CYC + 1);
  localparam int OW = $clog2(PREAMBLE_MIN + 1);

  localparam logic [1:0] E_TIME  = 2'd1;
  localparam logic [1:0] E_PAR   = 2'd2;
  localparam logic [1:0] E_FRAME = 2'd3;

  typedef enum logic {ST_SEARCH, ST_RX} st_t;

  function automatic logic [4:0] hdr_len(input logic [7:0] h);
    logic [7:0] d;
    if (h < 8'h20) return 5'd1;
    if (h < 8'h80) begin
      d = h - 8'h20;
      return 5'd2 + 5'(d >> 4);
    end
    d = h - 8'h80;
    return 5'd8 + 5'(d >> 3);
  endfunction

  logic [1:0]    sync;
  logic          lvl;
  logic [GW-1:0] gcnt;
  logic          edge_p;
  logic [CW-1:0] iv_cnt;
  logic          half_pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], mod_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl    <= 1'b1;
      gcnt   <= '0;
      edge_p <= 1'b0;
    end else begin
      edge_p <= 1'b0;
      if (sync[1] != lvl) begin
        if (gcnt == GW'(GLITCH_CYC - 1)) begin
          lvl    <= sync[1];
          gcnt   <= '0;
          edge_p <= 1'b1;
        end else gcnt <= gcnt + 1'b1;
      end else gcnt <= '0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       iv_cnt <= '0;
    else if (edge_p)                  iv_cnt <= '0;
    else if (iv_cnt != CW'(L_MAX + 1)) iv_cnt <= iv_cnt + 1'b1;

  st_t st;
  wire [CW-1:0] iv_len = iv_cnt + 1'b1;
  wire is_s   = edge_p && iv_len >= CW'(S_MIN) && iv_len <= CW'(S_MAX);
  wire is_l   = edge_p && iv_len >= CW'(L_MIN) && iv_len <= CW'(L_MAX);
  wire is_bad = edge_p && !is_s && !is_l;
  wire tmo    = !edge_p && iv_cnt == CW'(L_MAX);

  wire bit_v    = (is_l && (!half_pend || st == ST_SEARCH)) || (is_s && half_pend);
  wire bit_val  = is_s;
  wire line_err = is_bad || tmo || (is_l && half_pend && st == ST_RX);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                half_pend <= 1'b0;
    else if (line_err || is_l) half_pend <= 1'b0;
    else if (is_s)             half_pend <= ~half_pend;

  logic [OW-1:0] ones;
  logic [3:0]    bidx;
  logic [7:0]    sh;
  logic          par;
  logic          first;
  logic [4:0]    rem;
  logic [7:0]    xsum;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st          <= ST_SEARCH;
      ones        <= '0;
      bidx        <= '0;
      sh          <= '0;
      par         <= 1'b0;
      first       <= 1'b0;
      rem         <= '0;
      xsum        <= '0;
      byte_o      <= '0;
      byte_vld_o  <= 1'b0;
      pkt_start_o <= 1'b0;
      pkt_end_o   <= 1'b0;
      chk_err_o   <= 1'b0;
      err_o       <= 1'b0;
      err_code_o  <= '0;
    end else begin
      byte_vld_o  <= 1'b0;
      pkt_start_o <= 1'b0;
      pkt_end_o   <= 1'b0;
      chk_err_o   <= 1'b0;
      err_o       <= 1'b0;
      if (st == ST_SEARCH) begin
        if (line_err) ones <= '0;
        else if (bit_v) begin
          if (bit_val) begin
            if (ones != OW'(PREAMBLE_MIN)) ones <= ones + 1'b1;
          end else begin
            if (ones == OW'(PREAMBLE_MIN)) begin
              st    <= ST_RX;
              bidx  <= 4'd1;
              first <= 1'b1;
              xsum  <= '0;
            end
            ones <= '0;
          end
        end
      end else begin
        if (line_err) begin
          st         <= ST_SEARCH;
          err_o      <= 1'b1;
          err_code_o <= E_TIME;
        end else if (bit_v) begin
          if (bidx == 4'd0) begin
            if (bit_val) begin
              st         <= ST_SEARCH;
              err_o      <= 1'b1;
              err_code_o <= E_FRAME;
            end else bidx <= 4'd1;
          end else if (bidx <= 4'd8) begin
            sh   <= {bit_val, sh[7:1]};
            bidx <= bidx + 1'b1;
          end else if (bidx == 4'd9) begin
            par  <= bit_val;
            bidx <= 4'd10;
          end else if (!bit_val) begin
            st         <= ST_SEARCH;
            err_o      <= 1'b1;
            err_code_o <= E_FRAME;
          end else if ((^sh ^ par) == 1'b0) begin
            st         <= ST_SEARCH;
            err_o      <= 1'b1;
            err_code_o <= E_PAR;
          end else begin
            byte_o     <= sh;
            byte_vld_o <= 1'b1;
            bidx       <= 4'd0;
            if (first) begin
              first       <= 1'b0;
              pkt_start_o <= 1'b1;
              rem         <= hdr_len(sh);
              xsum        <= sh;
            end else if (rem == 5'd0) begin
              pkt_end_o <= 1'b1;
              chk_err_o <= (xsum != sh);
              st        <= ST_SEARCH;
            end else begin
              rem  <= rem - 1'b1;
              xsum <= xsum ^ sh;
            end
          end
        end
      end
    end
endmodule

module biphase_pkt_demod_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_vld_o,
  input logic       pkt_start_o,
  input logic       pkt_end_o,
  input logic       chk_err_o,
  input logic       err_o,
  input logic [1:0] err_code_o
);
  // R6
  start_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start_o |-> byte_vld_o);
  // R6
  end_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end_o |-> byte_vld_o);
  // R6
  start_end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pkt_start_o, pkt_end_o}));
  // R7
  chk_err_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_err_o |-> pkt_end_o);
  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (err_code_o != 2'd0 && !byte_vld_o));
  // R10
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !byte_vld_o);
endmodule

bind biphase_pkt_demod biphase_pkt_demod_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld_o(byte_vld_o), .pkt_start_o(pkt_start_o),
  .pkt_end_o(pkt_end_o), .chk_err_o(chk_err_o), .err_o(err_o), .err_code_o(err_code_o)
);

// File: tb/sim_biphase_pkt_demod.sv
module sim_biphase_pkt_demod;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 20;
  localparam int FULL = 2 * HALF;
  localparam int GL   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b1;
  logic [7:0] byte_o;
  logic byte_vld_o, pkt_start_o, pkt_end_o, chk_err_o, err_o;
  logic [1:0] err_code_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  biphase_pkt_demod #(.HALF_CYC(HALF), .GLITCH_CYC(GL), .PREAMBLE_MIN(11)) u0 (
    .clk(clk), .rst_n(rst_n), .mod_i(line), .byte_o(byte_o), .byte_vld_o(byte_vld_o),
    .pkt_start_o(pkt_start_o), .pkt_end_o(pkt_end_o), .chk_err_o(chk_err_o),
    .err_o(err_o), .err_code_o(err_code_o));

  int n_cmp = 0, n_bad = 0, nb = 0, nerr = 0;
  logic [1:0] last_code;
  logic [7:0] cap_b [0:63];
  logic cap_s [0:63];
  logic cap_e [0:63];
  logic cap_c [0:63];
  logic [7:0] msg [0:31];
  bit done = 0;

  always @(negedge clk) begin
    if (byte_vld_o && nb < 64) begin
      cap_b[nb] = byte_o; cap_s[nb] = pkt_start_o;
      cap_e[nb] = pkt_end_o; cap_c[nb] = chk_err_o;
      nb = nb + 1;
    end
    if (err_o) begin nerr = nerr + 1; last_code = err_code_o; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tog();
    line = ~line;
  endtask

  task automatic send_bit(input bit b, input bit glitch, input int len);
    tog();
    if (b) begin wait_cyc(HALF); tog(); wait_cyc(HALF); end
    else if (glitch) begin wait_cyc(17); tog(); wait_cyc(3); tog(); wait_cyc(len - 20); end
    else wait_cyc(len);
  endtask

  task automatic send_byte(input logic [7:0] d, input bit flip_par, input bit stop, input bit gl);
    send_bit(1'b0, gl, FULL);
    for (int i = 0; i < 8; i++) send_bit(d[i], gl, FULL);
    send_bit(~(^d) ^ flip_par, gl, FULL);
    send_bit(stop, gl, FULL);
  endtask

  task automatic send_pre(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1, 1'b0, FULL);
  endtask

  task automatic close_line();
    tog();
    wait_cyc(4 * FULL);
  endtask

  task automatic clear_cap();
    wait_cyc(2);
    nb = 0; nerr = 0; last_code = 2'd0;
  endtask

  function automatic int exp_len(input logic [7:0] h);
    if (h < 8'h20) return 1;
    if (h < 8'h80) return 2 + ((h - 8'h20) >> 4);
    return 8 + ((h - 8'h80) >> 3);
  endfunction

  task automatic run_packet(input logic [7:0] hdr, input bit bad_chk, input bit gl, input string req);
    int n;
    logic [7:0] x;
    n = exp_len(hdr);
    x = hdr;
    for (int i = 0; i < n; i++) begin msg[i] = 8'(8'h3C + i * 37) ^ hdr; x = x ^ msg[i]; end
    clear_cap();
    send_pre(14);
    send_byte(hdr, 1'b0, 1'b1, gl);
    for (int i = 0; i < n; i++) send_byte(msg[i], 1'b0, 1'b1, gl);
    send_byte(x ^ {7'd0, bad_chk}, 1'b0, 1'b1, gl);
    close_line();
    check(nb == n + 2, {req, " R5 byte count"}, nb, n + 2);
    check(nb > 0 && cap_b[0] == hdr && cap_s[0], {req, " R4 R6 header"}, int'(cap_b[0]), int'(hdr));
    for (int i = 0; i < n && i + 1 < nb; i++)
      check(cap_b[i+1] == msg[i] && !cap_s[i+1] && !cap_e[i+1], {req, " R2 R4 message byte"},
            int'(cap_b[i+1]), int'(msg[i]));
    if (nb == n + 2) begin
      check(cap_e[n+1] && cap_b[n+1] == (x ^ {7'd0, bad_chk}), {req, " R6 end flag"}, int'(cap_e[n+1]), 1);
      check(cap_c[n+1] == bad_chk, {req, " R7 checksum flag"}, int'(cap_c[n+1]), int'(bad_chk));
    end
    check(nerr == 0, {req, " R11 no error strobe"}, nerr, 0);
  endtask

  task automatic t_reset();
    check(!byte_vld_o && !pkt_start_o && !pkt_end_o && !chk_err_o && !err_o && byte_o == 0 && err_code_o == 0,
          "R12 reset outputs", int'(byte_vld_o), 0);
  endtask

  task automatic t_short_preamble();
    clear_cap();
    send_pre(8);
    send_byte(8'h05, 1'b0, 1'b1, 1'b0);
    send_byte(8'h11, 1'b0, 1'b1, 1'b0);
    close_line();
    check(nb == 0, "R3 short preamble ignored", nb, 0);
    check(nerr == 0, "R11 short preamble silent", nerr, 0);
  endtask

  task automatic t_abort(input int kind, input logic [1:0] code, input string req);
    clear_cap();
    send_pre(12);
    send_byte(8'h07, 1'b0, 1'b1, 1'b0);
    case (kind)
      0: send_byte(8'h5A, 1'b1, 1'b1, 1'b0);
      1: send_byte(8'h5A, 1'b0, 1'b0, 1'b0);
      2: begin send_bit(1'b0, 1'b0, FULL); send_bit(1'b0, 1'b0, 28); end
      3: send_bit(1'b1, 1'b0, FULL);
      default: ;
    endcase
    close_line();
    check(nb == 1, {req, " bytes before abort"}, nb, 1);
    check(nerr == 1 && last_code == code, {req, " error cause"}, int'(last_code), int'(code));
  endtask

  task automatic t_search_noise();
    clear_cap();
    for (int i = 0; i < 6; i++) begin tog(); wait_cyc(28); end
    for (int i = 0; i < 3; i++) begin tog(); wait_cyc(9); end
    close_line();
    check(nerr == 0 && nb == 0, "R11 noise in search silent", nerr, 0);
  endtask

  initial begin
    wait_cyc(3);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(4 * FULL);
    run_packet(8'h05, 1'b0, 1'b0, "R2 short header");
    run_packet(8'h31, 1'b0, 1'b0, "R5 mid header");
    run_packet(8'h90, 1'b0, 1'b0, "R5 long header");
    run_packet(8'h1F, 1'b1, 1'b0, "R7 bad checksum");
    run_packet(8'h02, 1'b0, 1'b1, "R1 glitches");
    t_short_preamble();
    t_abort(0, 2'd2, "R8 parity");
    t_abort(1, 2'd3, "R9 stop bit");
    t_abort(3, 2'd3, "R9 missing start bit");
    t_abort(2, 2'd1, "R10 gap out of window");
    t_abort(4, 2'd1, "R10 silence timeout");
    t_search_noise();
    run_packet(8'h21, 1'b0, 1'b0, "R3 recovery after errors");
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule